// File: doc/BRIEF.md
# NCO Phase Word Generator with Discrete PSK

This block produces the 32-bit instantaneous phase word that drives the sine and cosine lookup of a quadrature numerically controlled oscillator. The whole phase range 0 through 2^32-1 is one turn of the unit circle, counterclockwise from zero. On every enabled clock a phase accumulator advances by the sum of two programmed frequency steps. One is a center step and the other is a delta step, for example for frequency modulation around the center. A registered, active-low carry input can add one more unit to each step.

A 16-bit phase offset is added to the upper half of the accumulated phase to form the output word. The offset is reloaded on every clock from one of two sources, picked by a registered select pin. The first source is a software-written phase input register. The second is three modulation pins, which give up to eight evenly spaced PSK levels. On that second path the pins fill the top three offset bits and the rest are zero.

The phase word leaves the block as a free-running sample stream with one new word per clock. There is no valid/ready pair, because the downstream lookup takes one word every cycle and cannot apply back-pressure. A consumer that needs to pause uses the accumulator enable, which freezes the accumulated phase. The offset path stays live while the accumulator is frozen. Registers are written through a plain address, data and write-strobe port.

Top module: `nco_phase_gen`

## Requirements
- R1: While `rst` is high at a clock edge, every internal register clears to zero. After two edges with `rst` high, `phase_out` reads 0.
- R2: With `acc_en` high and the carry inactive, `phase_out` advances by (center step + delta step) mod 2^32 between consecutive clocks once the inputs have been steady for 6 clocks. The sum wraps modulo 2^32.
- R3: While `acc_en` is low, the accumulated phase holds. With the offset source steady, `phase_out` then stays constant from clock to clock.
- R4: `carry_in_n` is active low and registered. While it is held low with `acc_en` high, each step grows by exactly 1.
- R5: When `mod_sel` is high (registered), the 16-bit offset equals the phase input register. It is added as bits [31:16], so `phase_out` exceeds the frozen accumulated phase by (phase input << 16) mod 2^32.
- R6: When `mod_sel` is low (registered), the offset is {`mod_pins`[2:0], 13'b0}. `phase_out` exceeds the frozen accumulated phase by `mod_pins` << 29, which covers all 8 levels.
- R7: A write with `wr_en` high updates one register selected by `wr_addr`. Address 0 is the center step, 1 is the delta step, and 2 is the phase input, which takes `wr_data`[15:0]. A write to any other address (3 to 7) changes no register.
- R8: A change on `mod_pins` reaches `phase_out` on the third rising edge after it is applied. After two edges the old value is still shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select for a write |
| wr_data | input | 32 | Write data |
| mod_sel | input | 1 | Offset source: 1 = phase input register, 0 = modulation pins |
| mod_pins | input | 3 | PSK level for the pin path |
| carry_in_n | input | 1 | Accumulator carry-in, active low |
| acc_en | input | 1 | Accumulator enable, active high |
| phase_out | output | 32 | Instantaneous phase word |

## Verification
The accumulator is driven with several step pairs, and each pair separates a different fault. They include a plain small step, steps whose sum wraps past 2^32, a pair that sums to exactly zero, and a mixed-bit pair. The mixed-bit pair exposes a missing or swapped addend. The offset path is swept over all eight PSK pin levels and several phase input values with the accumulator frozen. This tells apart a wrong bit alignment, a missing zero fill and a wrong source select. Separate runs cover the carry input, the enable hold, writes to unused addresses and the exact latency of a pin change. These show that each control acts on its own and at the specified cycle.

// File: rtl/nco_pg_pkg.sv
package nco_pg_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    ADR_CENTER = 3'd0,
    ADR_DELTA  = 3'd1,
    ADR_PHASE  = 3'd2
  } reg_addr_e;
endpackage

// File: rtl/nco_pg_regs.sv
module nco_pg_regs
  import nco_pg_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int OFS_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [PHASE_W-1:0] wr_data,
  output logic [PHASE_W-1:0] center_o,
  output logic [PHASE_W-1:0] delta_o,
  output logic [OFS_W-1:0]   pin_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      center_o <= '0;
      delta_o  <= '0;
      pin_o    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CENTER: center_o <= wr_data;
        ADR_DELTA:  delta_o  <= wr_data;
        ADR_PHASE:  pin_o    <= wr_data[OFS_W-1:0];
        default: ;
      endcase
    end
  end

  AST_UNUSED_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > ADR_PHASE) |=> ($stable(center_o) && $stable(delta_o) && $stable(pin_o))); // R7

endmodule

// File: rtl/nco_pg_offset.sv
module nco_pg_offset #(
  parameter int OFS_W = 16,
  parameter int MOD_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mod_sel,
  input  logic [MOD_W-1:0] mod_pins,
  input  logic             carry_in_n,
  input  logic [OFS_W-1:0] pin_i,
  output logic [OFS_W-1:0] ofs_o,
  output logic             cin_o
);
  localparam int FILL_W = OFS_W - MOD_W;

  logic             sel_q;
  logic [MOD_W-1:0] mod_q;
  logic [OFS_W-1:0] psk_word;

  generate
    if (FILL_W > 0) begin : g_fill
      assign psk_word = {mod_q, {FILL_W{1'b0}}};
    end else begin : g_nofill
      assign psk_word = mod_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      mod_q <= '0;
      cin_o <= 1'b0;
      ofs_o <= '0;
    end else begin
      sel_q <= mod_sel;
      mod_q <= mod_pins;
      cin_o <= ~carry_in_n;
      ofs_o <= sel_q ? pin_i : psk_word;
    end
  end

  AST_PSK_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    !sel_q |=> (ofs_o[FILL_W-1:0] == '0)); // R6
  AST_PSK_TOP_PINS: assert property (@(posedge clk) disable iff (rst)
    !sel_q |=> (ofs_o[OFS_W-1:FILL_W] == $past(mod_q))); // R6
  AST_SEL_PHASE_REG: assert property (@(posedge clk) disable iff (rst)
    sel_q |=> (ofs_o == $past(pin_i))); // R5

endmodule

// File: rtl/nco_pg_accum.sv
module nco_pg_accum #(
  parameter int PHASE_W = 32,
  parameter int OFS_W   = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_en,
  input  logic [PHASE_W-1:0] center_i,
  input  logic [PHASE_W-1:0] delta_i,
  input  logic               cin_i,
  input  logic [OFS_W-1:0]   ofs_i,
  output logic [PHASE_W-1:0] phase_o
);
  localparam int SHIFT_W = PHASE_W - OFS_W;

  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] step;
  logic [PHASE_W-1:0] ofs_wide;

  assign step = center_i + delta_i + {{(PHASE_W-1){1'b0}}, cin_i};

  generate
    if (SHIFT_W > 0) begin : g_align
      assign ofs_wide = {ofs_i, {SHIFT_W{1'b0}}};
    end else begin : g_direct
      assign ofs_wide = ofs_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      phase_o <= '0;
    end else begin
      if (acc_en) acc_q <= acc_q + step;
      phase_o <= acc_q + ofs_wide;
    end
  end

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> $stable(acc_q)); // R3
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && phase_o == '0)); // R1

endmodule

// File: rtl/nco_phase_gen.sv
module nco_phase_gen
  import nco_pg_pkg::*;
#(
  parameter int PHASE_W = 32,
  parameter int OFS_W   = 16,
  parameter int MOD_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [PHASE_W-1:0] wr_data,
  input  logic               mod_sel,
  input  logic [MOD_W-1:0]   mod_pins,
  input  logic               carry_in_n,
  input  logic               acc_en,
  output logic [PHASE_W-1:0] phase_out
);

  logic [PHASE_W-1:0] center;
  logic [PHASE_W-1:0] delta;
  logic [OFS_W-1:0]   pin_reg;
  logic [OFS_W-1:0]   ofs;
  logic               cin;

  nco_pg_regs #(.PHASE_W(PHASE_W), .OFS_W(OFS_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .center_o(center), .delta_o(delta), .pin_o(pin_reg)
  );

  nco_pg_offset #(.OFS_W(OFS_W), .MOD_W(MOD_W)) offset_i (
    .clk(clk), .rst(rst), .mod_sel(mod_sel), .mod_pins(mod_pins),
    .carry_in_n(carry_in_n), .pin_i(pin_reg), .ofs_o(ofs), .cin_o(cin)
  );

  nco_pg_accum #(.PHASE_W(PHASE_W), .OFS_W(OFS_W)) accum_i (
    .clk(clk), .rst(rst), .acc_en(acc_en), .center_i(center), .delta_i(delta),
    .cin_i(cin), .ofs_i(ofs), .phase_o(phase_out)
  );

endmodule

// File: tb/nco_phase_gen_tb.sv
`timescale 1ns/1ps
module nco_phase_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic        mod_sel;
  logic [2:0]  mod_pins;
  logic        carry_in_n;
  logic        acc_en;
  logic [31:0] phase_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  nco_phase_gen dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mod_sel(mod_sel), .mod_pins(mod_pins), .carry_in_n(carry_in_n),
    .acc_en(acc_en), .phase_out(phase_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  // R2 / R4: step between consecutive words equals center + delta (+1 with carry)
  task automatic run_step(input logic [31:0] c, input logic [31:0] d, input bit cy, input string req);
    logic [31:0] prev;
    logic [31:0] exp;
    wr(3'd0, c);
    wr(3'd1, d);
    carry_in_n = ~cy;
    acc_en = 1'b1;
    cyc(6);
    exp = c + d + {31'd0, cy};
    prev = phase_out;
    for (int i = 0; i < 4; i++) begin
      cyc(1);
      chk((phase_out - prev) == exp, req, phase_out - prev, exp);
      prev = phase_out;
    end
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    mod_sel = 1'b0; mod_pins = '0; carry_in_n = 1'b1; acc_en = 1'b0;
    cyc(3);
    chk(phase_out == 32'd0, "R1", phase_out, 32'd0);
    rst = 1'b0;
    cyc(2);
    chk(phase_out == 32'd0, "R1", phase_out, 32'd0);

    // R2 sweep of step pairs including wrap and zero-sum cases
    run_step(32'h0000_0001, 32'h0000_0000, 1'b0, "R2");
    run_step(32'h0001_0000, 32'h0000_0003, 1'b0, "R2");
    run_step(32'hFFFF_FFF0, 32'h0000_0020, 1'b0, "R2");
    run_step(32'h8000_0000, 32'h8000_0000, 1'b0, "R2");
    run_step(32'h1234_5678, 32'hFEDC_BA98, 1'b0, "R2");
    run_step(32'h0000_0000, 32'h4000_0001, 1'b0, "R2");
    // R4 carry input
    run_step(32'h0000_0005, 32'h0000_0007, 1'b1, "R4");
    run_step(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R4");

    // R3 hold with accumulator disabled
    carry_in_n = 1'b1;
    acc_en = 1'b0;
    cyc(4);
    begin
      logic [31:0] held;
      held = phase_out;
      for (int i = 0; i < 4; i++) begin
        cyc(1);
        chk(phase_out == held, "R3", phase_out, held);
      end
    end

    // R6 exhaustive PSK levels, R8 latency
    begin
      logic [31:0] base;
      logic [31:0] exp;
      mod_sel = 1'b0; mod_pins = 3'd0;
      cyc(4);
      base = phase_out;
      for (int m = 1; m < 8; m++) begin
        mod_pins = 3'(m);
        cyc(4);
        exp = base + (32'(m) << 29);
        chk(phase_out == exp, "R6", phase_out, exp);
      end
      mod_pins = 3'd0;
      cyc(4);
      chk(phase_out == base, "R6", phase_out, base);

      mod_pins = 3'd5;
      cyc(2);
      chk(phase_out == base, "R8", phase_out, base);
      cyc(1);
      exp = base + (32'd5 << 29);
      chk(phase_out == exp, "R8", phase_out, exp);
      mod_pins = 3'd0;
      cyc(4);

      // R5 phase input register path
      mod_sel = 1'b1;
      for (int k = 0; k < 4; k++) begin
        logic [31:0] pv;
        pv = 32'h5A5A_0000 | 32'(16'h0001 << (k * 5)) | (k == 3 ? 32'h0000_FFFF : 32'd0);
        wr(3'd2, pv);
        cyc(4);
        exp = base + {pv[15:0], 16'h0000};
        chk(phase_out == exp, "R5", phase_out, exp);
      end

      // R7 writes to unused addresses leave all registers alone
      wr(3'd2, 32'h0000_1357);
      cyc(4);
      for (int a = 3; a < 8; a++) wr(3'(a), 32'hDEAD_BEEF);
      cyc(4);
      exp = base + 32'h1357_0000;
      chk(phase_out == exp, "R7", phase_out, exp);
      mod_sel = 1'b0;
    end
    // R7: frequency registers still hold the last R4 pair after unused-address writes
    begin
      logic [31:0] prev;
      logic [31:0] exp;
      carry_in_n = 1'b1;
      acc_en = 1'b1;
      cyc(6);
      exp = 32'hFFFF_FFFF;
      prev = phase_out;
      cyc(1);
      chk((phase_out - prev) == exp, "R7", phase_out - prev, exp);
    end

    // R1 reset in mid-run
    rst = 1'b1;
    cyc(2);
    chk(phase_out == 32'd0, "R1", phase_out, 32'd0);
    rst = 1'b0;
    cyc(3);
    chk(phase_out == 32'd0, "R1", phase_out, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule